// File: doc/BRIEF.md
# USB Host Transmit Endpoint Control and Status Register

This block holds the 8-bit control and status byte for one host-side transmit endpoint of a USB controller. A CPU writes the byte through a simple strobe-qualified write port and can read it at any time. The endpoint transaction engine reports what happened on the wire through single-cycle event pulses: acknowledge, NAK, STALL, transaction error and no response. It also supplies the current FIFO fill level and a frame tick. In return, the block drives a transmit request, the token choice (SETUP or OUT), the data-toggle state, a one-cycle FIFO flush pulse and a one-cycle DMA abort pulse.

The bits do not all behave the same way. Some are plain read/write. Some are status flags that the CPU can only clear, by writing 0. Two are action bits that read back as 0. Several events also have side effects on other bits: a STALL empties the FIFO, drops the pending packet and aborts DMA, and arming SETUP resets the data toggle. For bulk endpoints, a NAK-duration timer halts the endpoint when the device has been NAKing for longer than a programmable number of frames.

No data stream passes through this block, so it has no valid/ready handshake. All of its pins are plain control and status signals, sampled or driven on the rising clock edge.

Top module: `usb_htx_ctrl`

## Requirements
- R1: After reset the register reads 0x00, the data toggle is 0, and tx_req, tok_setup, fifo_flush and dma_abort are all low.
- R2: Bit layout: bit 0 packet-ready, bit 1 FIFO-not-empty, bit 2 error, bit 3 flush action, bit 4 SETUP select, bit 5 stall-received, bit 6 toggle-reset action, bit 7 NAK-timeout/no-response. Bits 3 and 6 always read back as 0.
- R3: Bits 7, 5 and 2 are cleared by a write with that bit at 0, and a written 1 leaves them unchanged. A hardware set in the same cycle as a CPU clear wins. ev_err sets bit 2 in both modes.
- R4: A write sets or clears bit 0. tx_req is high while bit 0 is 1 and bit 7 is 0. An ev_ack clears bit 0 and inverts the data toggle.
- R5: Bit 4 is plain read/write, and tok_setup follows it. A write that changes bit 4 from 0 to 1 resets the data toggle to 0. Rewriting 1 while bit 4 is already 1 leaves the toggle alone.
- R6: Writing 1 to bit 6 resets the data toggle to 0.
- R7: An ev_stall sets bit 5 and clears bit 0 in the next cycle, and raises fifo_flush and dma_abort for exactly that one cycle.
- R8: Writing 1 to bit 3 while bit 0 is 0 (both before the write and in the written byte) gives a one-cycle fifo_flush in the next cycle and clears bit 1. While bit 0 is 1, the flush request is ignored.
- R9: Bit 1 becomes 1 in any cycle where fifo_level is non-zero. Once fifo_level is zero, a write with bit 1 at 0 clears it. A flush clears it even when the level is non-zero.
- R10: In bulk mode (ep_bulk=1) with nak_limit L>0, an ev_nak starts counting frame_tick pulses. Bit 7 becomes 1 after tick L+1. Any ev_ack, ev_stall, ev_err or ev_noresp stops and clears the count. A limit of 0 disables the timeout.
- R11: While bit 7 is 1, tx_req is low. A CPU clear of bit 7 resumes transmission and discards the count, so a fresh ev_nak is needed before the timer runs again.
- R12: In interrupt mode (ep_bulk=0), ev_noresp sets bit 7 and the NAK timer never fires. In bulk mode, ev_noresp sets bit 2 instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | CPU write strobe |
| bus_wdata | input | 8 | CPU write byte |
| bus_rdata | output | 8 | Current register byte |
| ep_bulk | input | 1 | 1 = bulk endpoint, 0 = high-bandwidth interrupt endpoint |
| nak_limit | input | NAK_W | NAK timeout in frames, 0 disables |
| frame_tick | input | 1 | One pulse per (micro)frame |
| ev_ack | input | 1 | Packet acknowledged |
| ev_nak | input | 1 | NAK handshake received |
| ev_stall | input | 1 | STALL handshake received |
| ev_err | input | 1 | Transaction error |
| ev_noresp | input | 1 | Device gave no response |
| fifo_level | input | LVL_W | Current transmit FIFO fill level |
| tx_req | output | 1 | Request to send the pending packet |
| tok_setup | output | 1 | 1 = send SETUP token, 0 = OUT token |
| data_toggle | output | 1 | Current data toggle (DATA0/DATA1) |
| fifo_flush | output | 1 | One-cycle FIFO flush pulse |
| dma_abort | output | 1 | One-cycle DMA abort pulse |

## Verification
The bound checker watches, on every cycle, the one-cycle effects that can be stated as properties. These are the STALL side effects, write-0-only clearing of the status flags, hardware-set priority, the toggle reset on bit 6 and on a SETUP arm, the toggle flip on acknowledge, the flush block while a packet is pending, and the halt holding tx_req low. The directed scenarios cover what spans many cycles or depends on history. That includes the exact frame count at which the NAK timeout fires, the restart after a non-NAK response or a CPU clear, the disabled zero limit, the mode-dependent routing of no-response, and the sticky FIFO-not-empty bit.

// File: rtl/usb_htx_pkg.sv
package usb_htx_pkg;
  localparam int REG_W      = 8;
  localparam int B_READY    = 0;
  localparam int B_NONEMPTY = 1;
  localparam int B_ERR      = 2;
  localparam int B_FLUSH    = 3;
  localparam int B_SETUP    = 4;
  localparam int B_STALL    = 5;
  localparam int B_TGLCLR   = 6;
  localparam int B_HALT     = 7;
  // clear-only status flags, index order used by the flag generate loop
  localparam int N_FLAGS    = 3;
  localparam int F_HALT     = 0;
  localparam int F_STALL    = 1;
  localparam int F_ERR      = 2;

  function automatic int flag_bit(input int idx);
    case (idx)
      F_HALT:  return B_HALT;
      F_STALL: return B_STALL;
      default: return B_ERR;
    endcase
  endfunction
endpackage

// File: rtl/usb_htx_wdec.sv
module usb_htx_wdec
  import usb_htx_pkg::*;
(
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             ready_q,
  input  logic             setup_q,
  output logic [REG_W-1:0] zero_mask,
  output logic             setup_rise,
  output logic             tgl_reset,
  output logic             flush_req
);
  // a bit position written as 0 in a valid write
  always_comb begin
    for (int i = 0; i < REG_W; i++) zero_mask[i] = wr & ~wdata[i];
  end

  assign setup_rise = wr & wdata[B_SETUP] & ~setup_q;
  assign tgl_reset  = wr & wdata[B_TGLCLR];
  // flush only when no packet is pending now nor being armed by this write
  assign flush_req  = wr & wdata[B_FLUSH] & ~wdata[B_READY] & ~ready_q;
endmodule

// File: rtl/usb_htx_flag.sv
module usb_htx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic cpu_clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       q <= 1'b0;
    else if (hw_set)  q <= 1'b1;
    else if (cpu_clr) q <= 1'b0;
  end
endmodule

// File: rtl/usb_htx_toggle.sv
module usb_htx_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic flip,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= 1'b0;
    else if (clr)  q <= 1'b0;
    else if (flip) q <= ~q;
  end
endmodule

// File: rtl/usb_htx_nak_timer.sv
module usb_htx_nak_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] limit,
  input  logic             ev_nak,
  input  logic             abort,
  input  logic             halted,
  input  logic             frame_tick,
  output logic             expire
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic             live;
  logic             tick_ok;

  assign live    = enable && (limit != '0);
  assign tick_ok = run_q && frame_tick && !halted;
  // fires on the tick that would take the count above the limit
  assign expire  = live && tick_ok && (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n || !live || abort) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (ev_nak) run_q <= 1'b1;
      if (tick_ok && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/usb_htx_ctrl.sv
module usb_htx_ctrl
  import usb_htx_pkg::*;
#(
  parameter int NAK_W = 16,
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             ep_bulk,
  input  logic [NAK_W-1:0] nak_limit,
  input  logic             frame_tick,
  input  logic             ev_ack,
  input  logic             ev_nak,
  input  logic             ev_stall,
  input  logic             ev_err,
  input  logic             ev_noresp,
  input  logic [LVL_W-1:0] fifo_level,
  output logic             tx_req,
  output logic             tok_setup,
  output logic             data_toggle,
  output logic             fifo_flush,
  output logic             dma_abort
);
  logic [REG_W-1:0]   zero_mask;
  logic               setup_rise, tgl_reset, flush_req, flush_fire;
  logic               ready_q, nonempty_q, setup_q, flush_q, abort_q;
  logic [N_FLAGS-1:0] flag_q, flag_set, flag_clr;
  logic               nak_expire, non_nak, halt_cpu_clr;

  usb_htx_wdec u_wdec (
    .wr         (bus_wr),
    .wdata      (bus_wdata),
    .ready_q    (ready_q),
    .setup_q    (setup_q),
    .zero_mask  (zero_mask),
    .setup_rise (setup_rise),
    .tgl_reset  (tgl_reset),
    .flush_req  (flush_req)
  );

  assign flag_set[F_HALT]  = nak_expire | (~ep_bulk & ev_noresp);
  assign flag_set[F_STALL] = ev_stall;
  assign flag_set[F_ERR]   = ev_err | (ep_bulk & ev_noresp);

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    localparam int P = flag_bit(g);
    assign flag_clr[g] = zero_mask[P];
    usb_htx_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .hw_set  (flag_set[g]),
      .cpu_clr (flag_clr[g]),
      .q       (flag_q[g])
    );
  end

  assign non_nak      = ev_ack | ev_stall | ev_err | ev_noresp;
  assign halt_cpu_clr = flag_clr[F_HALT] & flag_q[F_HALT];

  usb_htx_nak_timer #(.CNT_W(NAK_W)) u_nak (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (ep_bulk),
    .limit      (nak_limit),
    .ev_nak     (ev_nak),
    .abort      (non_nak | halt_cpu_clr),
    .halted     (flag_q[F_HALT]),
    .frame_tick (frame_tick),
    .expire     (nak_expire)
  );

  usb_htx_toggle u_tgl (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tgl_reset | setup_rise),
    .flip  (ev_ack),
    .q     (data_toggle)
  );

  assign flush_fire = ev_stall | flush_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q    <= 1'b0;
      nonempty_q <= 1'b0;
      setup_q    <= 1'b0;
      flush_q    <= 1'b0;
      abort_q    <= 1'b0;
    end else begin
      if (ev_stall || ev_ack)          ready_q <= 1'b0;
      else if (bus_wr)                 ready_q <= bus_wdata[B_READY];

      if (flush_fire)                  nonempty_q <= 1'b0;
      else if (fifo_level != '0)       nonempty_q <= 1'b1;
      else if (zero_mask[B_NONEMPTY])  nonempty_q <= 1'b0;

      if (bus_wr)                      setup_q <= bus_wdata[B_SETUP];

      flush_q <= flush_fire;
      abort_q <= ev_stall;
    end
  end

  always_comb begin
    bus_rdata             = '0;
    bus_rdata[B_READY]    = ready_q;
    bus_rdata[B_NONEMPTY] = nonempty_q;
    bus_rdata[B_ERR]      = flag_q[F_ERR];
    bus_rdata[B_SETUP]    = setup_q;
    bus_rdata[B_STALL]    = flag_q[F_STALL];
    bus_rdata[B_HALT]     = flag_q[F_HALT];
  end

  assign tx_req     = ready_q & ~flag_q[F_HALT];
  assign tok_setup  = setup_q;
  assign fifo_flush = flush_q;
  assign dma_abort  = abort_q;
endmodule

// File: rtl/usb_htx_ctrl_chk.sv
module usb_htx_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       ev_ack,
  input logic       ev_stall,
  input logic       ev_err,
  input logic       tx_req,
  input logic       data_toggle,
  input logic       fifo_flush,
  input logic       dma_abort
);
  assert_stall_effects_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stall |=> bus_rdata[5] && !bus_rdata[0] && fifo_flush && dma_abort);

  assert_abort_with_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_abort |-> fifo_flush);

  assert_w0c_ignores_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_wdata[5] && bus_rdata[5] |=> bus_rdata[5]);

  assert_hw_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |=> bus_rdata[2]);

  assert_toggle_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_wdata[6] |=> !data_toggle);

  assert_setup_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_wdata[4] && !bus_rdata[4] |=> !data_toggle);

  assert_ack_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack && !ev_stall && !bus_wr |=> data_toggle != $past(data_toggle) && !bus_rdata[0]);

  assert_flush_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_wdata[3] && bus_rdata[0] && !ev_stall |=> !fifo_flush);

  assert_halt_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[7] |-> !tx_req);

  assert_action_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[3] == 1'b0 && bus_rdata[6] == 1'b0);
endmodule

bind usb_htx_ctrl usb_htx_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wr      (bus_wr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .ev_ack      (ev_ack),
  .ev_stall    (ev_stall),
  .ev_err      (ev_err),
  .tx_req      (tx_req),
  .data_toggle (data_toggle),
  .fifo_flush  (fifo_flush),
  .dma_abort   (dma_abort)
);

// File: tb/usb_htx_ctrl_bench.sv
module usb_htx_ctrl_bench;
  localparam int NAK_W = 16;
  localparam int LVL_W = 7;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bus_wr = 1'b0;
  logic [7:0]       bus_wdata = '0;
  logic [7:0]       bus_rdata;
  logic             ep_bulk = 1'b1;
  logic [NAK_W-1:0] nak_limit = '0;
  logic             frame_tick = 1'b0;
  logic             ev_ack = 1'b0, ev_nak = 1'b0, ev_stall = 1'b0;
  logic             ev_err = 1'b0, ev_noresp = 1'b0;
  logic [LVL_W-1:0] fifo_level = '0;
  logic             tx_req, tok_setup, data_toggle, fifo_flush, dma_abort;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  usb_htx_ctrl #(.NAK_W(NAK_W), .LVL_W(LVL_W)) u_usb_htx_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ep_bulk(ep_bulk), .nak_limit(nak_limit),
    .frame_tick(frame_tick), .ev_ack(ev_ack), .ev_nak(ev_nak),
    .ev_stall(ev_stall), .ev_err(ev_err), .ev_noresp(ev_noresp),
    .fifo_level(fifo_level), .tx_req(tx_req), .tok_setup(tok_setup),
    .data_toggle(data_toggle), .fifo_flush(fifo_flush), .dma_abort(dma_abort)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    bus_wr = 1'b1; bus_wdata = d; cyc(); bus_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      frame_tick = 1'b1; cyc(); frame_tick = 1'b0;
    end
  endtask

  task automatic do_reset();
    bus_wr = 0; ev_ack = 0; ev_nak = 0; ev_stall = 0; ev_err = 0; ev_noresp = 0;
    frame_tick = 0; fifo_level = '0; ep_bulk = 1'b1; nak_limit = '0;
    rst_n = 1'b0; cyc(); cyc(); rst_n = 1'b1; cyc();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "rdata", bus_rdata, 8'h00);
    chk("R1", "outputs", {tx_req, tok_setup, data_toggle, fifo_flush, dma_abort}, 5'b0);
  endtask

  task automatic t_ready_ack();
    do_reset();
    wr(8'h01);
    chk("R4", "ready bit", bus_rdata[0], 1'b1);
    chk("R4", "tx_req", tx_req, 1'b1);
    ev_ack = 1; cyc(); ev_ack = 0;
    chk("R4", "ready after ack", bus_rdata[0], 1'b0);
    chk("R4", "toggle after ack", data_toggle, 1'b1);
    ev_ack = 1; cyc(); ev_ack = 0;
    chk("R4", "toggle second ack", data_toggle, 1'b0);
    wr(8'h01); wr(8'h00);
    chk("R4", "ready cleared by write", {bus_rdata[0], tx_req}, 2'b00);
  endtask

  task automatic t_setup_toggle();
    do_reset();
    ev_ack = 1; cyc(); ev_ack = 0;
    wr(8'h11);
    chk("R5", "setup bit/tok", {bus_rdata[4], tok_setup}, 2'b11);
    chk("R5", "toggle reset on arm", data_toggle, 1'b0);
    ev_ack = 1; cyc(); ev_ack = 0;
    wr(8'h11);
    chk("R5", "rewrite keeps toggle", data_toggle, 1'b1);
    wr(8'h40);
    chk("R6", "toggle reset bit", data_toggle, 1'b0);
    chk("R2", "action bits read 0", bus_rdata, 8'h00);
  endtask

  task automatic t_w0c();
    do_reset();
    ev_err = 1; cyc(); ev_err = 0;
    chk("R3", "err set", bus_rdata[2], 1'b1);
    wr(8'h04);
    chk("R3", "write 1 ignored", bus_rdata[2], 1'b1);
    wr(8'h00);
    chk("R3", "write 0 clears", bus_rdata[2], 1'b0);
    ev_err = 1; bus_wr = 1; bus_wdata = 8'h00; cyc(); ev_err = 0; bus_wr = 0;
    chk("R3", "hw set beats clear", bus_rdata[2], 1'b1);
  endtask

  task automatic t_stall();
    do_reset();
    wr(8'h01);
    ev_stall = 1; cyc(); ev_stall = 0;
    chk("R7", "rdata after stall", bus_rdata, 8'h20);
    chk("R7", "flush/abort pulse", {fifo_flush, dma_abort}, 2'b11);
    cyc();
    chk("R7", "pulses one cycle", {fifo_flush, dma_abort}, 2'b00);
    ev_stall = 1; bus_wr = 1; bus_wdata = 8'h00; cyc(); ev_stall = 0; bus_wr = 0;
    chk("R3", "stall set beats clear", bus_rdata[5], 1'b1);
  endtask

  task automatic t_flush();
    do_reset();
    fifo_level = 7'd5; cyc();
    chk("R9", "nonempty set", bus_rdata[1], 1'b1);
    wr(8'h08);
    chk("R8", "flush pulse", fifo_flush, 1'b1);
    chk("R8", "nonempty cleared", bus_rdata[1], 1'b0);
    fifo_level = '0; cyc();
    chk("R8", "flush one cycle", fifo_flush, 1'b0);
    wr(8'h09);
    chk("R8", "flush with arm ignored", fifo_flush, 1'b0);
    wr(8'h08);
    chk("R8", "flush while pending ignored", fifo_flush, 1'b0);
  endtask

  task automatic t_nonempty();
    do_reset();
    fifo_level = 7'd3; cyc(); fifo_level = '0; cyc();
    chk("R9", "sticky after empty", bus_rdata[1], 1'b1);
    wr(8'h02);
    chk("R9", "write 1 keeps", bus_rdata[1], 1'b1);
    fifo_level = 7'd1; wr(8'h00);
    chk("R9", "clear blocked by level", bus_rdata[1], 1'b1);
    fifo_level = '0; wr(8'h00);
    chk("R9", "write 0 clears", bus_rdata[1], 1'b0);
  endtask

  task automatic t_nak_timeout();
    do_reset();
    nak_limit = 16'd3;
    wr(8'h01);
    ev_nak = 1; cyc(); ev_nak = 0;
    ticks(3);
    chk("R10", "no timeout after L ticks", {bus_rdata[7], tx_req}, 2'b01);
    ticks(1);
    chk("R10", "timeout after L+1 ticks", bus_rdata[7], 1'b1);
    chk("R11", "halt blocks tx_req", tx_req, 1'b0);
    wr(8'h01);
    chk("R11", "cpu clear resumes", {bus_rdata[7], tx_req}, 2'b01);
    ticks(6);
    chk("R11", "count discarded", bus_rdata[7], 1'b0);
  endtask

  task automatic t_nak_restart();
    do_reset();
    nak_limit = 16'd3;
    ev_nak = 1; cyc(); ev_nak = 0;
    ticks(3);
    ev_ack = 1; cyc(); ev_ack = 0;
    ticks(3);
    chk("R10", "ack clears count", bus_rdata[7], 1'b0);
    ev_nak = 1; cyc(); ev_nak = 0;
    ticks(3);
    chk("R10", "fresh run not yet", bus_rdata[7], 1'b0);
    ticks(1);
    chk("R10", "fresh run expires", bus_rdata[7], 1'b1);
  endtask

  task automatic t_limit_zero();
    do_reset();
    nak_limit = '0;
    ev_nak = 1; cyc(); ev_nak = 0;
    ticks(10);
    chk("R10", "limit 0 disables", bus_rdata[7], 1'b0);
  endtask

  task automatic t_modes();
    do_reset();
    ep_bulk = 1'b0; nak_limit = 16'd1;
    ev_noresp = 1; cyc(); ev_noresp = 0;
    chk("R12", "intr noresp -> bit7 only", {bus_rdata[7], bus_rdata[2]}, 2'b10);
    wr(8'h00);
    ev_nak = 1; cyc(); ev_nak = 0;
    ticks(4);
    chk("R12", "no timer in intr mode", bus_rdata[7], 1'b0);
    ep_bulk = 1'b1;
    ev_noresp = 1; cyc(); ev_noresp = 0;
    chk("R12", "bulk noresp -> bit2 only", {bus_rdata[7], bus_rdata[2]}, 2'b01);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_ready_ack();
    t_setup_toggle();
    t_w0c();
    t_stall();
    t_flush();
    t_nonempty();
    t_nak_timeout();
    t_nak_restart();
    t_limit_zero();
    t_modes();
    finish_run();
  end
endmodule